// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Cause Flag

This block watches a controller's software for signs of life. A prescaler divides the oscillator clock into a slow watchdog tick, and each tick advances an up-counter. Software keeps the block quiet by writing a two-byte key sequence to a key address, which clears the counter. If the counter overflows, the block fires. It also fires at once if software writes the control register with a wrong check pattern while the block is enabled.

When it fires, a mode input sampled at that moment decides the action. In reset mode the block pulls its active-low reset output low for a fixed number of oscillator cycles. In interrupt mode it pulls its active-low interrupt output low for the same window. The pulse length does not depend on the prescaler setting. A sticky flag in the control register is set when a reset-mode pulse ends. Only the power-on reset or an explicit write of one clears it, so software can read the flag after restart to learn the cause of the reset.

Two small state machines make up the control. The key tracker has states `KS_IDLE` and `KS_HALF`. A write of 0x55 takes it to `KS_HALF` (arm). A write of 0xAA in `KS_HALF` services the counter and returns to `KS_IDLE` (service). Any other key write returns it to `KS_IDLE` (cancel). The pulse machine has states `PS_WATCH` and `PS_FIRE`. A trip moves it from `PS_WATCH` to `PS_FIRE` (trip). When the pulse counter reaches its last count, it moves back from `PS_FIRE` to `PS_WATCH` (release).

Top module: `wd_keyed_top`

## Requirements
- R1: After power-on reset the control register reads 0x00, meaning enabled, flag clear and prescale code 000. Both `wd_rst_n` and `wd_irq_n` are high.
- R2: A control write (`reg_addr`=0) with `wprot_en` high and check bits [5:3]=101 loads the disable bit [6] and the prescale code [2:0]. A control write with `wprot_en` low changes nothing.
- R3: A protected control write whose bits [5:3] are not 101 leaves every field unchanged. If the disable bit is 0, it starts the watchdog action on the next cycle. If the disable bit is 1, it has no effect.
- R4: Reading either address (0 = control, 1 = key) returns {flag, disable, 3'b000, prescale} on `reg_rdata`.
- R5: The watchdog tick comes every BASE_DIV*F oscillator cycles. F is 1 for codes 000 and 001 and 2^(code-1) otherwise. After a pulse ends, both the prescaler and the counter restart from zero.
- R6: A tick that arrives while the CNT_W-bit counter holds all ones, with the block enabled, starts the watchdog action on the next cycle.
- R7: Writing 0x55 and then 0xAA as consecutive key writes (`reg_addr`=1) clears the counter, even in the very cycle that would otherwise overflow. A lone 0xAA does not clear it. A 0x55 followed by any value other than 0xAA does not clear it either.
- R8: In reset mode (`irq_mode`=0 when the block trips), `wd_rst_n` stays low for exactly PULSE_CYC oscillator cycles and `wd_irq_n` stays high.
- R9: In interrupt mode (`irq_mode`=1 when the block trips), `wd_irq_n` stays low for exactly PULSE_CYC cycles, `wd_rst_n` stays high, and the flag is not set.
- R10: The flag (bit 7) is set when a reset-mode pulse ends. A valid control write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it unchanged. If the pulse ends in the same cycle as a clearing write, the flag is set.
- R11: While a pulse is active, further trips, including bad-check writes, are ignored, and the pulse keeps its full length.
- R12: While the disable bit is 1, the counter holds and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = key register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register contents (both addresses) |
| wprot_en | input | 1 | Protected-write enable for the control register |
| irq_mode | input | 1 | Action select at trip: 0 = reset pulse, 1 = interrupt pulse |
| wd_rst_n | output | 1 | Active-low reset pulse |
| wd_irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The hardest case to reach from the ports is a service that completes in the very cycle in which the counter would overflow. The bench tracks its own model's prescaler and counter. It waits for the negative edge at which the model shows the counter at all ones with a tick due, and only then issues the 0xAA write. A similar case is a flag-clearing write that lands on the last cycle of a reset pulse. The bench reaches it by timing that write against the model's pulse count.

// File: rtl/wd_pkg.sv
package wd_pkg;
    typedef enum logic {PS_WATCH, PS_FIRE} pulse_state_e;
    typedef enum logic {KS_IDLE, KS_HALF} key_state_e;

    localparam logic [2:0] CHK_PATTERN = 3'b101;
    localparam logic [7:0] KEY_OPEN    = 8'h55;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam int FLAG_BIT = 7;
    localparam int DIS_BIT  = 6;
    localparam int CHK_HI   = 5;
    localparam int CHK_LO   = 3;
    localparam int PS_HI    = 2;
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int BASE_DIV = 512,
    parameter int PRE_W    = $clog2(BASE_DIV) + 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic [2:0]       shamt;

    always_comb begin
        shamt = (sel < 3'd2) ? 3'd0 : (sel - 3'd1);
        lim   = (PRE_W'(BASE_DIV) << shamt) - PRE_W'(1);
        tick  = !hold && (pre_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pre_q <= '0;
        else if (hold)       pre_q <= '0;
        else if (tick)       pre_q <= '0;
        else                 pre_q <= pre_q + PRE_W'(1);
    end

    // R5
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || hold) |=> (pre_q == '0));
endmodule

// File: rtl/wd_key_seq.sv
module wd_key_seq
    import wd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       svc_clr
);
    key_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            unique case (st_q)
                KS_IDLE: st_d = (key_data == KEY_OPEN) ? KS_HALF : KS_IDLE;
                KS_HALF: st_d = (key_data == KEY_OPEN) ? KS_HALF : KS_IDLE;
                default: st_d = KS_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_clr = key_wr && (st_q == KS_HALF) && (key_data == KEY_CLOSE);
    end

    // R7
    svc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clr |=> (st_q == KS_IDLE));
endmodule

// File: rtl/wd_pulse_fsm.sv
module wd_pulse_fsm
    import wd_pkg::*;
#(
    parameter int PULSE_CYC = 512,
    parameter int PC_W      = $clog2(PULSE_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic irq_mode,
    output logic active,
    output logic done_rst,
    output logic rst_out_n,
    output logic irq_out_n
);
    localparam logic [PC_W-1:0] LAST = PC_W'(PULSE_CYC - 1);

    pulse_state_e st_q;
    logic [PC_W-1:0] pc_q;
    logic mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_WATCH;
            pc_q   <= '0;
            mode_q <= 1'b0;
        end else begin
            unique case (st_q)
                PS_WATCH: begin
                    pc_q <= '0;
                    if (trip) begin
                        st_q   <= PS_FIRE;
                        mode_q <= irq_mode;
                    end
                end
                PS_FIRE: begin
                    if (pc_q == LAST) begin
                        st_q <= PS_WATCH;
                        pc_q <= '0;
                    end else begin
                        pc_q <= pc_q + PC_W'(1);
                    end
                end
                default: st_q <= PS_WATCH;
            endcase
        end
    end

    always_comb begin
        active    = (st_q == PS_FIRE);
        done_rst  = active && (pc_q == LAST) && !mode_q;
        rst_out_n = !(active && !mode_q);
        irq_out_n = !(active && mode_q);
    end

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pc_q == LAST) |=> !active);
    // R11
    pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pc_q != LAST) |=> (active && $stable(mode_q)));
endmodule

// File: rtl/wd_keyed_top.sv
module wd_keyed_top
    import wd_pkg::*;
#(
    parameter int BASE_DIV  = 512,
    parameter int CNT_W     = 8,
    parameter int PULSE_CYC = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       wprot_en,
    input  logic       irq_mode,
    output logic       wd_rst_n,
    output logic       wd_irq_n
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic flag_q, dis_q;
    logic [2:0] ps_q;
    logic [CNT_W-1:0] cnt_q;
    logic ctrl_wr, key_wr, prot_wr, chk_ok, good_wr, bad_wr;
    logic tick, svc_clr, ovf, trip, active, done_rst;

    always_comb begin
        ctrl_wr = reg_wr && !reg_addr;
        key_wr  = reg_wr && reg_addr;
        prot_wr = ctrl_wr && wprot_en;
        chk_ok  = (reg_wdata[CHK_HI:CHK_LO] == CHK_PATTERN);
        good_wr = prot_wr && chk_ok;
        bad_wr  = prot_wr && !chk_ok;
        ovf     = tick && !dis_q && (cnt_q == CNT_MAX);
        trip    = !active && ((ovf && !svc_clr) || (bad_wr && !dis_q));
        reg_rdata = {flag_q, dis_q, 3'b000, ps_q};
    end

    wd_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(active), .sel(ps_q), .tick(tick)
    );

    wd_key_seq u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(reg_wdata),
        .svc_clr(svc_clr)
    );

    wd_pulse_fsm #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trip(trip), .irq_mode(irq_mode),
        .active(active), .done_rst(done_rst),
        .rst_out_n(wd_rst_n), .irq_out_n(wd_irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
            ps_q  <= 3'b000;
        end else if (good_wr) begin
            dis_q <= reg_wdata[DIS_BIT];
            ps_q  <= reg_wdata[PS_HI:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            flag_q <= 1'b0;
        else if (done_rst)                     flag_q <= 1'b1;
        else if (good_wr && reg_wdata[FLAG_BIT]) flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (active)          cnt_q <= '0;
        else if (svc_clr)         cnt_q <= '0;
        else if (tick && !dis_q)  cnt_q <= cnt_q + CNT_W'(1);
    end

    // R8 R9
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wd_rst_n && !wd_irq_n));
    // R2
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wprot_en) |=> $stable({dis_q, ps_q}));
    // R10
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(!wd_rst_n));
    // R12
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !active && !svc_clr) |=> $stable(cnt_q));
    // R3
    bad_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && !dis_q && !active) |=> active);
endmodule

// File: tb/wd_keyed_top_test.sv
module wd_keyed_top_test;
    localparam int BASE  = 8;
    localparam int CW    = 4;
    localparam int PULSE = 512;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0, wprot_en = 1'b0, irq_mode = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic wd_rst_n, wd_irq_n;

    int total = 0, bad = 0;
    int m_pre, m_cnt, m_armed, m_st, m_pc, m_mode, m_flag, m_dis, m_ps;
    int rst_falls = 0;
    logic prev_rst = 1'b1;
    logic started = 1'b0;

    always #5 clk = ~clk;

    wd_keyed_top #(.BASE_DIV(BASE), .CNT_W(CW), .PULSE_CYC(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wprot_en(wprot_en),
        .irq_mode(irq_mode), .wd_rst_n(wd_rst_n), .wd_irq_n(wd_irq_n)
    );

    function automatic int lim_of(int ps);
        return BASE * (1 << ((ps < 2) ? 0 : ps - 1)) - 1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_armed = 0; m_st = 0; m_pc = 0;
            m_mode = 0; m_flag = 0; m_dis = 0; m_ps = 0;
        end else begin : upd
            int lim;
            bit cw, kw, good, badw, svc, act, tick, ovf, fire, done;
            lim  = lim_of(m_ps);
            cw   = reg_wr && !reg_addr;
            kw   = reg_wr && reg_addr;
            good = cw && wprot_en && (reg_wdata[5:3] == 3'b101);
            badw = cw && wprot_en && (reg_wdata[5:3] != 3'b101);
            svc  = kw && (m_armed != 0) && (reg_wdata == 8'hAA);
            act  = (m_st != 0);
            tick = !act && (m_pre >= lim);
            ovf  = tick && (m_dis == 0) && (m_cnt == CMAX);
            fire = !act && ((ovf && !svc) || (badw && m_dis == 0));
            done = act && (m_pc == PULSE - 1);
            if (act || svc) m_cnt = 0;
            else if (tick && m_dis == 0) m_cnt = (m_cnt + 1) & CMAX;
            if (act || tick) m_pre = 0; else m_pre = m_pre + 1;
            if (done && m_mode == 0) m_flag = 1;
            else if (good && reg_wdata[7]) m_flag = 0;
            if (good) begin m_dis = reg_wdata[6]; m_ps = reg_wdata[2:0]; end
            if (kw) m_armed = (reg_wdata == 8'h55) ? 1 : 0;
            if (!act) begin
                if (fire) begin m_st = 1; m_pc = 0; m_mode = irq_mode; end
            end else if (done) begin m_st = 0; m_pc = 0; end
            else m_pc = m_pc + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(wd_rst_n == !(m_st != 0 && m_mode == 0), "R8 rst_n vs model",
                wd_rst_n, !(m_st != 0 && m_mode == 0));
            chk(wd_irq_n == !(m_st != 0 && m_mode != 0), "R9 irq_n vs model",
                wd_irq_n, !(m_st != 0 && m_mode != 0));
            chk(reg_rdata == {m_flag[0], m_dis[0], 3'b000, m_ps[2:0]},
                "R4 rdata vs model", reg_rdata,
                {m_flag[0], m_dis[0], 3'b000, m_ps[2:0]});
            if (prev_rst && !wd_rst_n) rst_falls++;
            prev_rst = wd_rst_n;
        end
    end

    task automatic bus_wr(logic a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, f0, lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        chk(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 8'h00);
        chk(wd_rst_n && wd_irq_n, "R1 reset outputs", {wd_rst_n, wd_irq_n}, 2'b11);

        wprot_en = 1'b0;
        bus_wr(1'b0, 8'h6F);
        chk(reg_rdata == 8'h00, "R2 unprotected write ignored", reg_rdata, 8'h00);
        wprot_en = 1'b1;
        bus_wr(1'b0, 8'h2B);
        chk(reg_rdata == 8'h03, "R2 protected write", reg_rdata, 8'h03);
        reg_addr = 1'b1;
        #1 chk(reg_rdata == 8'h03, "R4 key address read", reg_rdata, 8'h03);
        @(negedge clk); reg_addr = 1'b0;

        // first overflow, reset mode, prescale code 3
        n = 0;
        while (wd_rst_n && n < 3000) begin n++; @(negedge clk); end
        n = 0; lows = 0;
        while (!wd_rst_n) begin n++; if (!wd_irq_n) lows++; @(negedge clk); end
        chk(n == PULSE, "R8 reset pulse width", n, PULSE);
        chk(lows == 0, "R8 irq idle during reset pulse", lows, 0);
        chk(reg_rdata[7], "R10 flag set after reset pulse", reg_rdata, 8'h83);
        n = 0;
        while (wd_rst_n && n < 3000) begin n++; @(negedge clk); end
        chk(n == 16 * 32, "R5 R6 overflow period code 3", n, 16 * 32);

        // bad write during pulse is ignored
        reg_wr = 1'b1; reg_wdata = 8'h00; n = 0;
        while (!wd_rst_n) begin n++; @(negedge clk); reg_wr = 1'b0; end
        chk(n == PULSE, "R11 pulse length with bad write inside", n, PULSE);
        chk(reg_rdata == 8'h83, "R11 fields unchanged", reg_rdata, 8'h83);

        bus_wr(1'b0, 8'h2B);
        chk(reg_rdata == 8'h83, "R10 write of 0 keeps flag", reg_rdata, 8'h83);
        bus_wr(1'b0, 8'hAB);
        chk(reg_rdata == 8'h03, "R10 write of 1 clears flag", reg_rdata, 8'h03);

        // interrupt mode
        irq_mode = 1'b1;
        n = 0;
        while (wd_irq_n && n < 3000) begin n++; @(negedge clk); end
        n = 0; lows = 0;
        while (!wd_irq_n) begin n++; if (!wd_rst_n) lows++; @(negedge clk); end
        chk(n == PULSE, "R9 irq pulse width", n, PULSE);
        chk(lows == 0, "R9 rst idle during irq pulse", lows, 0);
        chk(reg_rdata[7] == 1'b0, "R9 flag not set by irq", reg_rdata, 8'h03);

        // prescale code 0
        reg_wr = 1'b1; reg_wdata = 8'h28; n = 0;
        while (wd_irq_n && n < 3000) begin n++; @(negedge clk); reg_wr = 1'b0; end
        chk(n == 16 * 8, "R5 overflow period code 0", n, 16 * 8);
        while (!wd_irq_n) @(negedge clk);
        irq_mode = 1'b0;

        // servicing keeps the block quiet
        f0 = rst_falls;
        for (int i = 0; i < 10; i++) begin
            bus_wr(1'b1, 8'h55);
            repeat (40) @(negedge clk);
            bus_wr(1'b1, 8'hAA);
        end
        chk(rst_falls == f0, "R7 full key pairs prevent trip", rst_falls - f0, 0);

        f0 = rst_falls;
        for (int i = 0; i < 6; i++) begin
            bus_wr(1'b1, 8'hAA);
            repeat (40) @(negedge clk);
        end
        chk(rst_falls > f0, "R7 lone second key does not service", rst_falls - f0, 1);
        while (!wd_rst_n) @(negedge clk);

        f0 = rst_falls;
        for (int i = 0; i < 4; i++) begin
            bus_wr(1'b1, 8'h55);
            bus_wr(1'b1, 8'h12);
            bus_wr(1'b1, 8'hAA);
            repeat (40) @(negedge clk);
        end
        chk(rst_falls > f0, "R7 broken pair does not service", rst_falls - f0, 1);
        while (!wd_rst_n) @(negedge clk);

        // service landing on the overflow tick
        bus_wr(1'b1, 8'h55);
        n = 0;
        while (!(m_st == 0 && m_cnt == CMAX && m_pre == lim_of(m_ps)) && n < 3000) begin
            n++; @(negedge clk);
        end
        f0 = rst_falls;
        bus_wr(1'b1, 8'hAA);
        repeat (20) @(negedge clk);
        chk(rst_falls == f0, "R7 service on overflow cycle", rst_falls - f0, 0);

        // bad check write trips at once
        bus_wr(1'b0, 8'hA8);
        bus_wr(1'b0, 8'h07);
        chk(!wd_rst_n, "R3 bad check trips next cycle", wd_rst_n, 0);
        chk(reg_rdata == 8'h00, "R3 bad write leaves fields", reg_rdata, 8'h00);

        // clear write on the last pulse cycle: set wins
        n = 0;
        while (!(m_st != 0 && m_pc == PULSE - 1) && n < 3000) begin n++; @(negedge clk); end
        bus_wr(1'b0, 8'hA8);
        chk(reg_rdata[7], "R10 set wins over clear", reg_rdata, 8'h80);

        // disabled block
        bus_wr(1'b0, 8'h68);
        f0 = rst_falls;
        bus_wr(1'b0, 8'h47);
        repeat (300) @(negedge clk);
        chk(rst_falls == f0, "R3 R12 no trip while disabled", rst_falls - f0, 0);
        chk(reg_rdata == 8'hC0, "R3 bad write ignored while disabled", reg_rdata, 8'hC0);
        bus_wr(1'b0, 8'h28);
        repeat (5) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule